// File: doc/BRIEF.md
# Power-Fail Guarded Two-Bank Chip-Enable Controller

This block sits between a memory bus and two banks of static RAM. It takes one active-low chip-enable from the bus and one bank-select address bit, and drives two active-low chip-enables, one per bank. An external voltage comparator gives the block a digital power-fail flag. While supply is good, the address bit steers the chip-enable to one bank. When the flag rises, the block stops accepting new accesses and protects both banks against writes.

Write protection does not cut off an access that is already under way. If the bus chip-enable is low on the clock edge where the synchronized power-fail flag is first seen, that access is allowed to run until the chip-enable returns high. A cycle counter limits how long this can take. When the counter expires, both bank enables are forced high whatever the bus does. The block also drives an active-high system reset. This reset is asserted while power is bad and for a programmable hold time after power comes back. Write protection ends on the same edge that the reset is released.

Top module: `bank_ce_guard`

## Requirements
- R1: While power is valid, a bank-select value of 0 routes the chip-enable input to ce1_n_o and a value of 1 routes it to ce2_n_o. The unselected output stays high. Each output reflects the inputs one clock edge after they are sampled.
- R2: At no time are both ce1_n_o and ce2_n_o low together, including when bank-select changes during an access.
- R3: When pfail_i rises while no access is in progress, both bank enables go high and sys_rst_o goes high on the third clock edge after pfail_i changes (two synchronizer stages plus the output register). On the second edge the outputs still show power-valid behaviour.
- R4: If ce_n_i is low on the edge where the synchronized power-fail is first seen, the access continues. The bank chosen on that edge stays enabled and later bank-select changes are ignored, and sys_rst_o stays low. One edge after ce_n_i returns high, both enables are high and sys_rst_o is high.
- R5: If such an access has not ended after WPT_CYCLES clock edges (default 50 MHz × 150 µs = 7500), counted from the edge that admitted it, both enables are forced high and sys_rst_o asserts on that edge. One edge earlier, the access is still enabled.
- R6: While write-protected, further falling edges of ce_n_i leave both enables high.
- R7: While rst_n is low, both enables are high and sys_rst_o is high.
- R8: When pfail_i falls, reset and write protection stay in force until clock edge 3 + RST_HOLD_CYCLES after the change. On that edge sys_rst_o drops and the enables follow the inputs again. On edge 2 + RST_HOLD_CYCLES they are still held.
- R9: If power-fail is seen again during the reset hold time, the block returns to protection and the hold time starts again from zero at the next power-valid.
- R10: After rst_n is released with pfail_i low, the block acts as a power-up. sys_rst_o drops on edge 3 + RST_HOLD_CYCLES after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail_i | input | 1 | Power-fail flag from the comparator, asynchronous, 1 = supply out of tolerance |
| ce_n_i | input | 1 | Bus chip-enable, active low |
| bank_sel_i | input | 1 | Bank-select address bit, 0 = bank 1, 1 = bank 2 |
| ce1_n_o | output | 1 | Conditioned chip-enable for bank 1, active low, registered |
| ce2_n_o | output | 1 | Conditioned chip-enable for bank 2, active low, registered |
| sys_rst_o | output | 1 | System reset, active high, registered |

## Verification
The decisive coincidence is a bus chip-enable falling on the same clock edge that the synchronized power-fail is first seen. On that edge, access decode and write-protect entry compete. The bench provokes this by dropping ce_n_i exactly two cycles after raising pfail_i. The correct outcome is that the new access is admitted and drains: the selected enable goes low, the reset stays low, and a later bank-select change is ignored. A second pattern holds the chip-enable high across that edge and checks that protection takes hold at once. A third holds the chip-enable low for the full timeout and checks the edge on which protection is forced.

// File: rtl/bank_ce_pkg.sv
package bank_ce_pkg;

   typedef enum logic [1:0] {
      ST_PROT  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_VALID = 2'd2,
      ST_DRAIN = 2'd3
   } guard_st_e;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/bank_ce_sync.sv
module bank_ce_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bank_ce_timer.sv
module bank_ce_timer
   import bank_ce_pkg::*;
#(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic done_o
);

   localparam int CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign done_o = active_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else if (!done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bank_ce_fsm.sv
module bank_ce_fsm
   import bank_ce_pkg::*;
#(
   parameter int WPT_CYCLES  = 7500,
   parameter int HOLD_CYCLES = 1000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pf_s_i,
   input  logic      ce_n_i,
   input  logic      bank_sel_i,
   output guard_st_e st_o,
   output guard_st_e ns_o,
   output logic      bank_eff_o
);

   guard_st_e st_q;
   guard_st_e ns;
   logic      bank_q;
   logic      wpt_done;
   logic      hold_done;
   logic      wpt_run;
   logic      hold_run;

   assign wpt_run  = (st_q == ST_DRAIN);
   assign hold_run = (st_q == ST_HOLD);

   bank_ce_timer #(.LIMIT(WPT_CYCLES)) u_wpt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (wpt_run),
      .done_o   (wpt_done)
   );

   bank_ce_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (hold_run),
      .done_o   (hold_done)
   );

   always_comb begin
      ns = st_q;
      case (st_q)
         ST_PROT: begin
            if (!pf_s_i) ns = ST_HOLD;
         end
         ST_HOLD: begin
            if (pf_s_i)         ns = ST_PROT;
            else if (hold_done) ns = ST_VALID;
         end
         ST_VALID: begin
            if (pf_s_i) ns = ce_n_i ? ST_PROT : ST_DRAIN;
         end
         ST_DRAIN: begin
            if (ce_n_i || wpt_done) ns = ST_PROT;
         end
         default: ns = ST_PROT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_PROT;
      else        st_q <= ns;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bank_q <= 1'b0;
      else if (st_q == ST_VALID)  bank_q <= bank_sel_i;
   end

   assign bank_eff_o = (st_q == ST_DRAIN) ? bank_q : bank_sel_i;
   assign st_o       = st_q;
   assign ns_o       = ns;

endmodule

// File: rtl/bank_ce_decode.sv
module bank_ce_decode #(
   parameter int NUM_BANKS = 2,
   parameter int SEL_W     = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
   input  logic                 en_i,
   input  logic                 ce_n_i,
   input  logic [SEL_W-1:0]     sel_i,
   output logic [NUM_BANKS-1:0] bank_ce_n_o
);

   generate
      genvar b;
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_ce_n_o[b] = !(en_i && !ce_n_i && (sel_i == SEL_W'(b)));
      end
   endgenerate

endmodule

// File: rtl/bank_ce_guard.sv
module bank_ce_guard
   import bank_ce_pkg::*;
#(
   parameter int CLK_HZ          = 50_000_000,
   parameter int WPT_US          = 150,
   parameter int RST_HOLD_CYCLES = 1000,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pfail_i,
   input  logic ce_n_i,
   input  logic bank_sel_i,
   output logic ce1_n_o,
   output logic ce2_n_o,
   output logic sys_rst_o
);

   localparam int NUM_BANKS  = 2;
   localparam int WPT_CYCLES = (CLK_HZ / 1_000_000) * WPT_US;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WPT_CYCLES < 2) begin : g_bad_wpt
         $error("write-protect timeout must be at least 2 cycles");
      end
      if (RST_HOLD_CYCLES < 1) begin : g_bad_hold
         $error("RST_HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic                 pf_s;
   guard_st_e            st_q;
   guard_st_e            ns;
   logic                 bank_eff;
   logic                 dec_en;
   logic [NUM_BANKS-1:0] bank_ce_n;
   logic                 rst_next;

   bank_ce_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pfail_i),
      .q_o   (pf_s)
   );

   bank_ce_fsm #(.WPT_CYCLES(WPT_CYCLES), .HOLD_CYCLES(RST_HOLD_CYCLES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pf_s_i     (pf_s),
      .ce_n_i     (ce_n_i),
      .bank_sel_i (bank_sel_i),
      .st_o       (st_q),
      .ns_o       (ns),
      .bank_eff_o (bank_eff)
   );

   assign dec_en   = (ns == ST_VALID) || (ns == ST_DRAIN);
   assign rst_next = (ns == ST_PROT) || (ns == ST_HOLD);

   bank_ce_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .en_i        (dec_en),
      .ce_n_i      (ce_n_i),
      .sel_i       (bank_eff),
      .bank_ce_n_o (bank_ce_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce1_n_o   <= 1'b1;
         ce2_n_o   <= 1'b1;
         sys_rst_o <= 1'b1;
      end else begin
         ce1_n_o   <= bank_ce_n[0];
         ce2_n_o   <= bank_ce_n[1];
         sys_rst_o <= rst_next;
      end
   end

endmodule

// File: rtl/bank_ce_guard_chk.sv
module bank_ce_guard_chk
   import bank_ce_pkg::*;
#(
   parameter int WPT_CYCLES = 7500
) (
   input logic      clk,
   input logic      rst_n,
   input logic      ce_n_i,
   input logic      bank_sel_i,
   input logic      ce1_n_o,
   input logic      ce2_n_o,
   input logic      sys_rst_o,
   input guard_st_e st
);

   int drain_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              drain_cnt <= 0;
      else if (st == ST_DRAIN) drain_cnt <= drain_cnt + 1;
      else                     drain_cnt <= 0;
   end

   p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VALID) |->
         (ce1_n_o == ($past(ce_n_i) || $past(bank_sel_i))) &&
         (ce2_n_o == ($past(ce_n_i) || !$past(bank_sel_i))));

   p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!ce1_n_o, !ce2_n_o}));

   p_protect_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_PROT) || (st == ST_HOLD)) |-> (ce1_n_o && ce2_n_o));

   p_drain_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN) |-> ((ce1_n_o != ce2_n_o) && !sys_rst_o));

   p_timeout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN) |-> (drain_cnt < WPT_CYCLES));

   p_reset_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_PROT) || (st == ST_HOLD)) |-> sys_rst_o);

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VALID) |-> !sys_rst_o);

endmodule

bind bank_ce_guard bank_ce_guard_chk #(.WPT_CYCLES(WPT_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n_i     (ce_n_i),
   .bank_sel_i (bank_sel_i),
   .ce1_n_o    (ce1_n_o),
   .ce2_n_o    (ce2_n_o),
   .sys_rst_o  (sys_rst_o),
   .st         (st_q)
);

// File: tb/sim_bank_ce_guard.sv
`timescale 1ns/1ps
module sim_bank_ce_guard;

   localparam int CLK_HZ = 50_000_000;
   localparam int WPT_US = 150;
   localparam int W      = (CLK_HZ / 1_000_000) * WPT_US;
   localparam int H      = 40;

   logic clk = 1'b0;
   logic rst_n;
   logic pfail;
   logic ce_n;
   logic bsel;
   logic ce1_n;
   logic ce2_n;
   logic srst;

   always #10 clk = ~clk;

   bank_ce_guard #(
      .CLK_HZ(CLK_HZ), .WPT_US(WPT_US), .RST_HOLD_CYCLES(H), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pfail_i(pfail), .ce_n_i(ce_n),
      .bank_sel_i(bsel), .ce1_n_o(ce1_n), .ce2_n_o(ce2_n), .sys_rst_o(srst)
   );

   typedef struct {
      int    at;
      logic  e1;
      logic  e2;
      logic  r;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int at, input logic e1, input logic e2,
                            input logic r, input string tag);
      exp_t it;
      it.at = at; it.e1 = e1; it.e2 = e2; it.r = r; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wait_to(input int at);
      while (cyc < at) @(negedge clk);
   endtask

   // monitor: compares outputs against the scoreboard at each falling edge
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
         exp_t it;
         it = q.pop_front();
         n_run++;
         if (it.at < cyc) begin
            n_fail++;
            $display("FAIL %s: sample missed at cycle %0d (now %0d)", it.tag, it.at, cyc);
         end else if (ce1_n !== it.e1 || ce2_n !== it.e2 || srst !== it.r) begin
            n_fail++;
            $display("FAIL %s @%0d: actual ce1=%b ce2=%b rst=%b expected ce1=%b ce2=%b rst=%b",
                     it.tag, cyc, ce1_n, ce2_n, srst, it.e1, it.e2, it.r);
         end
      end
   end

   initial begin
      int c;
      int c2;
      int d;
      pfail = 1'b0; ce_n = 1'b1; bsel = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      // R7: reset state
      c = cyc;
      expect_at(c + 1, 1, 1, 1, "R7 reset state");
      wait_to(c + 2);
      rst_n = 1'b1;
      // R10: power-up hold
      c = cyc;
      expect_at(c + 2 + H, 1, 1, 1, "R10 still held");
      expect_at(c + 3 + H, 1, 1, 0, "R10 released");
      wait_to(c + 3 + H);

      // R1 / R2: decode
      c = cyc;
      bsel = 1'b0; ce_n = 1'b0;
      expect_at(c + 1, 0, 1, 0, "R1 bank1 select");
      wait_to(c + 1); ce_n = 1'b1;
      expect_at(c + 2, 1, 1, 0, "R1 idle");
      wait_to(c + 2); bsel = 1'b1; ce_n = 1'b0;
      expect_at(c + 3, 1, 0, 0, "R1 bank2 select");
      wait_to(c + 3); bsel = 1'b0;
      expect_at(c + 4, 0, 1, 0, "R2 select switch to bank1");
      wait_to(c + 4); bsel = 1'b1;
      expect_at(c + 5, 1, 0, 0, "R2 select switch to bank2");
      wait_to(c + 5); ce_n = 1'b1;
      expect_at(c + 6, 1, 1, 0, "R1 access end");
      wait_to(c + 6);

      // R3: idle power-fail, then R6
      c = cyc;
      pfail = 1'b1;
      expect_at(c + 2, 1, 1, 0, "R3 synchronizer delay");
      expect_at(c + 3, 1, 1, 1, "R3 forced inactive");
      wait_to(c + 3); ce_n = 1'b0; bsel = 1'b0;
      expect_at(c + 4, 1, 1, 1, "R6 new access ignored bank1");
      wait_to(c + 5); ce_n = 1'b1;
      wait_to(c + 6); ce_n = 1'b0; bsel = 1'b1;
      expect_at(c + 8, 1, 1, 1, "R6 new access ignored bank2");
      wait_to(c + 8); ce_n = 1'b1;

      // R8: power returns
      c = cyc;
      pfail = 1'b0;
      expect_at(c + 2 + H, 1, 1, 1, "R8 hold before release");
      expect_at(c + 3 + H, 1, 1, 0, "R8 release");
      wait_to(c + 3 + H);

      // R4: access falls on the edge where power-fail is first seen
      c = cyc;
      bsel = 1'b1; pfail = 1'b1;
      wait_to(c + 2); ce_n = 1'b0;
      expect_at(c + 2, 1, 1, 0, "R4 before coincidence");
      expect_at(c + 3, 1, 0, 0, "R4 access admitted on fail edge");
      wait_to(c + 5); bsel = 1'b0;
      expect_at(c + 13, 1, 0, 0, "R4 latched bank holds");
      wait_to(c + 13); ce_n = 1'b1;
      expect_at(c + 14, 1, 1, 1, "R4 protect after access end");
      wait_to(c + 14); ce_n = 1'b0;
      expect_at(c + 15, 1, 1, 1, "R6 no re-enable after drain");
      wait_to(c + 15); ce_n = 1'b1;

      // R9: power-fail during the hold restarts it
      c = cyc;
      pfail = 1'b0;
      expect_at(c + 3 + H, 1, 1, 1, "R9 no release after restart");
      wait_to(c + 10); pfail = 1'b1;
      wait_to(c + 15); pfail = 1'b0;
      c2 = cyc;
      expect_at(c2 + 2 + H, 1, 1, 1, "R9 held before new release");
      expect_at(c2 + 3 + H, 1, 1, 0, "R9 release after full hold");
      wait_to(c2 + 3 + H);

      // R5: access never ends, timeout forces protection
      c = cyc;
      bsel = 1'b0; ce_n = 1'b0;
      expect_at(c + 1, 0, 1, 0, "R5 access starts");
      wait_to(c + 1); pfail = 1'b1;
      d = c + 4;
      expect_at(d + W - 1, 0, 1, 0, "R5 access still enabled before timeout");
      expect_at(d + W, 1, 1, 1, "R5 timeout forces inactive");
      wait_to(d + W); ce_n = 1'b1;
      expect_at(d + W + 1, 1, 1, 1, "R5 stays protected");
      wait_to(d + W + 1); pfail = 1'b0;
      c = cyc;
      expect_at(c + 3 + H, 1, 1, 0, "R8 final release");
      wait_to(c + 4 + H);

      while (q.size() > 0) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule